// File: doc/BRIEF.md
# Dual-Lane Conditional Execution Resolver

This block sits beside the instruction sequencer of a two-lane SIMD core. Each cycle it gets the condition outcome computed for lane X and for lane Y, a flag that says whether SIMD mode is on, an unconditional-instruction flag and the class of the operation being issued. It turns these into the strobes that the rest of the core acts on: a result write enable per lane, one branch-taken decision for the sequencer, an address-update enable for the address generator, and a flag that tells lane Y to take its data from the single unpaired source. These decisions are combinational, so they appear in the same cycle as their inputs.

Each operation class joins the two lane conditions by its own rule. Computes and paired moves are gated per lane. A branch needs both lanes true. A post-modify address update needs either lane true. A move into an unpaired register follows lane X alone. A pre-modify update ignores the condition. With SIMD mode off, lane X decides everything and every lane-Y enable stays low.

The block also holds a small stack of lane status words. A push saves the status words and a pop restores them. In SIMD mode both lanes' words move together. With SIMD mode off, only lane X's word moves. Stack results and error flags are registered and appear one cycle after the request.

Top module: `simd_cond_resolver`

## Requirements
- R1: For opClass 0 (compute) and opClass 2 (move between paired registers), wrEnX follows the lane X condition and wrEnY follows the lane Y condition, each lane independently.
- R2: For opClass 3 (move from an unpaired register into a paired one), each lane's write enable follows that lane's own condition, and shareSrc is high whenever SIMD mode is on.
- R3: For opClass 4 (move from a paired register into an unpaired one), wrEnX follows the lane X condition only and wrEnY stays low.
- R4: For opClass 1 (branch or loop end), branchTaken is high only when both lane conditions are true. It is low for every other class.
- R5: For opClass 5 (address modify) with preModify low, dagModEn is high when either lane condition is true.
- R6: For opClass 5 with preModify high, dagModEn is high regardless of both conditions.
- R7: With simdEn low, every rule uses the lane X condition alone, and wrEnY and shareSrc stay low.
- R8: With uncond high, both lane conditions count as true before any rule is applied.
- R9: opClass values 6 and 7 raise no write enable, no branch and no address update.
- R10: In SIMD mode a push stores statXIn and statYIn as one entry and a pop restores the most recent entry. The pop result appears on statXOut and statYOut with restoreX and restoreY high, one cycle after the request.
- R11: With simdEn low, a push writes only the lane X word of the new entry, leaving the lane Y word as it was. A pop raises restoreX alone, updates statXOut only and leaves statYOut unchanged.
- R12: A push onto a full stack (DEPTH entries, default 5) raises stkOverflow for one cycle and leaves the contents unchanged.
- R13: A pop from an empty stack raises stkUnderflow for one cycle, leaves the contents unchanged and raises no restore strobe.
- R14: A cycle with pushReq and popReq both high changes nothing and raises no flag and no restore strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| simdEn | input | 1 | SIMD mode on |
| condX | input | 1 | Condition result from lane X |
| condY | input | 1 | Condition result from lane Y |
| uncond | input | 1 | Instruction has no condition |
| opClass | input | 3 | Operation class code (see R1 to R9) |
| preModify | input | 1 | Address update is pre-modify |
| pushReq | input | 1 | Status stack push request |
| popReq | input | 1 | Status stack pop request |
| statXIn | input | W | Lane X status word to save |
| statYIn | input | W | Lane Y status word to save |
| wrEnX | output | 1 | Lane X destination write enable |
| wrEnY | output | 1 | Lane Y destination write enable |
| shareSrc | output | 1 | Lane Y takes the unpaired source |
| branchTaken | output | 1 | Branch or loop termination taken |
| dagModEn | output | 1 | Address generator update enable |
| statXOut | output | W | Restored lane X status word |
| statYOut | output | W | Restored lane Y status word |
| restoreX | output | 1 | statXOut was loaded by a pop |
| restoreY | output | 1 | statYOut was loaded by a pop |
| stkOverflow | output | 1 | Push refused, stack full |
| stkUnderflow | output | 1 | Pop refused, stack empty |

## Verification
Some rules can be checked on every cycle: lane Y quiet outside SIMD mode and for paired-to-unpaired moves, branches only on the branch class, a forced update on pre-modify, overflow and underflow flags following only a lone request, and restoreY never appearing without restoreX. Other behaviour needs a scenario to show it: the AND and OR combinations over all condition pairs, the effect of the unconditional flag, the last-in first-out order of saved words, a non-SIMD push keeping the old lane Y word of its entry, and stack contents surviving refused or colliding requests.

// File: rtl/simd_cond_pkg.sv
package simd_cond_pkg;

  localparam int IDX_MAX_W = 8;

  typedef enum logic [2:0] {
    OP_COMPUTE   = 3'd0,
    OP_BRANCH    = 3'd1,
    OP_MOVE_PP   = 3'd2,
    OP_MOVE_UP   = 3'd3,
    OP_MOVE_PU   = 3'd4,
    OP_ADDR_MOD  = 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } op_e;

  // strobes from stack control to stack storage
  typedef struct packed {
    logic                 wrX;
    logic                 wrY;
    logic                 rdX;
    logic                 rdY;
    logic [IDX_MAX_W-1:0] wrIdx;
    logic [IDX_MAX_W-1:0] rdIdx;
  } stk_strobe_t;

endpackage

// File: rtl/simd_cond_ctrl.sv
module simd_cond_ctrl
  import simd_cond_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        simdEn,
  input  logic        condX,
  input  logic        condY,
  input  logic        uncond,
  input  op_e         opCls,
  input  logic        preModify,
  input  logic        pushReq,
  input  logic        popReq,
  output logic        wrEnX,
  output logic        wrEnY,
  output logic        shareSrc,
  output logic        branchTaken,
  output logic        dagModEn,
  output logic        stkOverflow,
  output logic        stkUnderflow,
  output stk_strobe_t strb
);

  localparam int CW = $clog2(DEPTH + 1);

  // effective lane conditions
  logic effX, effY, laneYOn;

  always_comb begin
    effX    = condX | uncond;
    laneYOn = simdEn & (condY | uncond);
    effY    = simdEn ? (condY | uncond) : 1'b1;
  end

  // per-class combination rules
  always_comb begin
    wrEnX       = 1'b0;
    wrEnY       = 1'b0;
    shareSrc    = 1'b0;
    branchTaken = 1'b0;
    dagModEn    = 1'b0;
    unique case (opCls)
      OP_COMPUTE, OP_MOVE_PP: begin
        wrEnX = effX;
        wrEnY = laneYOn;
      end
      OP_MOVE_UP: begin
        wrEnX    = effX;
        wrEnY    = laneYOn;
        shareSrc = simdEn;
      end
      OP_MOVE_PU: begin
        wrEnX = effX;
      end
      OP_BRANCH: begin
        branchTaken = effX & effY;
      end
      OP_ADDR_MOD: begin
        dagModEn = preModify | effX | laneYOn;
      end
      default: begin
      end
    endcase
  end

  // stack occupancy control
  logic [CW-1:0] count;
  logic doPush, doPop, isFull, isEmpty;

  always_comb begin
    doPush  = pushReq & ~popReq;
    doPop   = popReq & ~pushReq;
    isFull  = (count == CW'(DEPTH));
    isEmpty = (count == '0);
  end

  always_comb begin
    strb       = '0;
    strb.wrX   = doPush & ~isFull;
    strb.wrY   = doPush & ~isFull & simdEn;
    strb.rdX   = doPop & ~isEmpty;
    strb.rdY   = doPop & ~isEmpty & simdEn;
    strb.wrIdx = IDX_MAX_W'(count);
    strb.rdIdx = IDX_MAX_W'(count - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count        <= '0;
      stkOverflow  <= 1'b0;
      stkUnderflow <= 1'b0;
    end else begin
      stkOverflow  <= doPush & isFull;
      stkUnderflow <= doPop & isEmpty;
      if (strb.wrX)      count <= count + CW'(1);
      else if (strb.rdX) count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/simd_stat_store.sv
module simd_stat_store
  import simd_cond_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  stk_strobe_t  strb,
  input  logic [W-1:0] statXIn,
  input  logic [W-1:0] statYIn,
  output logic [W-1:0] statXOut,
  output logic [W-1:0] statYOut,
  output logic         restoreX,
  output logic         restoreY
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] memX [DEPTH];
  logic [W-1:0] memY [DEPTH];
  logic [IW-1:0] wIdx, rIdx;

  always_comb begin
    wIdx = strb.wrIdx[IW-1:0];
    rIdx = strb.rdIdx[IW-1:0];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        memX[i] <= '0;
        memY[i] <= '0;
      end else begin
        if (strb.wrX && wIdx == IW'(i)) memX[i] <= statXIn;
        if (strb.wrY && wIdx == IW'(i)) memY[i] <= statYIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statXOut <= '0;
      statYOut <= '0;
      restoreX <= 1'b0;
      restoreY <= 1'b0;
    end else begin
      restoreX <= strb.rdX;
      restoreY <= strb.rdY;
      if (strb.rdX) statXOut <= memX[rIdx];
      if (strb.rdY) statYOut <= memY[rIdx];
    end
  end

endmodule

// File: rtl/simd_cond_resolver.sv
module simd_cond_resolver
  import simd_cond_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         simdEn,
  input  logic         condX,
  input  logic         condY,
  input  logic         uncond,
  input  logic [2:0]   opClass,
  input  logic         preModify,
  input  logic         pushReq,
  input  logic         popReq,
  input  logic [W-1:0] statXIn,
  input  logic [W-1:0] statYIn,
  output logic         wrEnX,
  output logic         wrEnY,
  output logic         shareSrc,
  output logic         branchTaken,
  output logic         dagModEn,
  output logic [W-1:0] statXOut,
  output logic [W-1:0] statYOut,
  output logic         restoreX,
  output logic         restoreY,
  output logic         stkOverflow,
  output logic         stkUnderflow
);

  stk_strobe_t strb;

  simd_cond_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .simdEn       (simdEn),
    .condX        (condX),
    .condY        (condY),
    .uncond       (uncond),
    .opCls        (op_e'(opClass)),
    .preModify    (preModify),
    .pushReq      (pushReq),
    .popReq       (popReq),
    .wrEnX        (wrEnX),
    .wrEnY        (wrEnY),
    .shareSrc     (shareSrc),
    .branchTaken  (branchTaken),
    .dagModEn     (dagModEn),
    .stkOverflow  (stkOverflow),
    .stkUnderflow (stkUnderflow),
    .strb         (strb)
  );

  simd_stat_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .statXIn  (statXIn),
    .statYIn  (statYIn),
    .statXOut (statXOut),
    .statYOut (statYOut),
    .restoreX (restoreX),
    .restoreY (restoreY)
  );

endmodule

// File: rtl/simd_cond_checker.sv
module simd_cond_checker (
  input logic       clk,
  input logic       rstN,
  input logic       simdEn,
  input logic [2:0] opClass,
  input logic       preModify,
  input logic       pushReq,
  input logic       popReq,
  input logic       wrEnY,
  input logic       shareSrc,
  input logic       branchTaken,
  input logic       dagModEn,
  input logic       restoreX,
  input logic       restoreY,
  input logic       stkOverflow,
  input logic       stkUnderflow
);

  a_r7_lane_y_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !simdEn |-> (!wrEnY && !shareSrc));

  a_r3_no_y_move: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == 3'd4) |-> !wrEnY);

  a_r4_branch_class: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (opClass == 3'd1));

  a_r6_pre_modify: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == 3'd5 && preModify) |-> dagModEn);

  a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rstN)
    (opClass[2:1] == 2'b11) |-> (!wrEnY && !branchTaken && !dagModEn));

  a_r12_overflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    stkOverflow |-> $past(pushReq && !popReq));

  a_r13_underflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    stkUnderflow |-> ($past(popReq && !pushReq) && !restoreX));

  a_r11_y_needs_x: assert property (@(posedge clk) disable iff (!rstN)
    restoreY |-> restoreX);

  a_r14_collision_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(pushReq && popReq) |-> (!restoreX && !stkOverflow && !stkUnderflow));

endmodule

bind simd_cond_resolver simd_cond_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .simdEn       (simdEn),
  .opClass      (opClass),
  .preModify    (preModify),
  .pushReq      (pushReq),
  .popReq       (popReq),
  .wrEnY        (wrEnY),
  .shareSrc     (shareSrc),
  .branchTaken  (branchTaken),
  .dagModEn     (dagModEn),
  .restoreX     (restoreX),
  .restoreY     (restoreY),
  .stkOverflow  (stkOverflow),
  .stkUnderflow (stkUnderflow)
);

// File: tb/sim_simd_cond_resolver.sv
`timescale 1ns/1ps
module sim_simd_cond_resolver;

  localparam int W = 16;
  localparam int DEPTH = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic simdEn = 1'b0, condX = 1'b0, condY = 1'b0, uncond = 1'b0;
  logic [2:0] opClass = 3'd7;
  logic preModify = 1'b0, pushReq = 1'b0, popReq = 1'b0;
  logic [W-1:0] statXIn = '0, statYIn = '0;
  logic wrEnX, wrEnY, shareSrc, branchTaken, dagModEn;
  logic [W-1:0] statXOut, statYOut;
  logic restoreX, restoreY, stkOverflow, stkUnderflow;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  simd_cond_resolver #(.DEPTH(DEPTH), .W(W)) u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected combinational outputs {wrEnX,wrEnY,shareSrc,branchTaken,dagModEn}
  function automatic logic [4:0] model(input logic [2:0] op, input logic s,
                                       input logic cx, input logic cy,
                                       input logic u, input logic pre);
    logic x, y;
    x = cx | u;
    y = s & (cy | u);
    case (op)
      3'd0, 3'd2: return {x, y, 3'b000};
      3'd3:       return {x, y, s, 2'b00};
      3'd4:       return {x, 4'b0000};
      3'd1:       return {3'b000, (s ? (x & y) : x), 1'b0};
      3'd5:       return {4'b0000, (pre | x | y)};
      default:    return 5'b00000;
    endcase
  endfunction

  task automatic combCase(input string tag, input logic [2:0] op, input logic s,
                          input logic cx, input logic cy, input logic u, input logic pre);
    @(negedge clk);
    opClass = op; simdEn = s; condX = cx; condY = cy; uncond = u; preModify = pre;
    #1;
    check(tag, 64'({wrEnX, wrEnY, shareSrc, branchTaken, dagModEn}),
          64'(model(op, s, cx, cy, u, pre)));
  endtask

  task automatic sweep(input string tag, input logic [2:0] op, input logic s,
                       input logic u, input logic pre);
    for (int c = 0; c < 4; c++) combCase(tag, op, s, c[1], c[0], u, pre);
  endtask

  task automatic stackOp(input logic s, input logic pu, input logic po,
                         input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    simdEn = s; pushReq = pu; popReq = po; statXIn = x; statYIn = y;
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
    #1;
  endtask

  // R1 R2 R3
  task automatic testMoves();
    sweep("R1 compute simd", 3'd0, 1'b1, 1'b0, 1'b0);
    sweep("R1 paired move simd", 3'd2, 1'b1, 1'b0, 1'b0);
    sweep("R2 unpaired to paired", 3'd3, 1'b1, 1'b0, 1'b0);
    sweep("R3 paired to unpaired", 3'd4, 1'b1, 1'b0, 1'b0);
  endtask

  // R4 R5 R6
  task automatic testBranchAddr();
    sweep("R4 branch AND", 3'd1, 1'b1, 1'b0, 1'b0);
    sweep("R5 post-modify OR", 3'd5, 1'b1, 1'b0, 1'b0);
    sweep("R6 pre-modify always", 3'd5, 1'b1, 1'b0, 1'b1);
    combCase("R4 branch on non-branch class", 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  // R7 R8 R9
  task automatic testModes();
    for (int op = 0; op < 6; op++) sweep("R7 non-SIMD", 3'(op), 1'b0, 1'b0, 1'b0);
    for (int op = 0; op < 6; op++) sweep("R8 unconditional", 3'(op), 1'b1, 1'b1, 1'b0);
    combCase("R8 unconditional branch both false", 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    sweep("R9 reserved 6", 3'd6, 1'b1, 1'b1, 1'b1);
    sweep("R9 reserved 7", 3'd7, 1'b1, 1'b0, 1'b1);
  endtask

  // R10
  task automatic testStackSimd();
    stackOp(1'b1, 1'b1, 1'b0, 16'h0011, 16'h0022);
    stackOp(1'b1, 1'b1, 1'b0, 16'h0033, 16'h0044);
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    check("R10 pop top", 64'({restoreX, restoreY, statXOut, statYOut}), 64'({2'b11, 16'h0033, 16'h0044}));
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    check("R10 pop bottom", 64'({restoreX, restoreY, statXOut, statYOut}), 64'({2'b11, 16'h0011, 16'h0022}));
    @(negedge clk);
    check("R10 restore is one cycle", 64'({restoreX, restoreY}), 64'(2'b00));
  endtask

  // R13
  task automatic testUnderflow();
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    check("R13 underflow flag", 64'({stkUnderflow, restoreX, restoreY}), 64'(3'b100));
    @(negedge clk);
    check("R13 underflow one cycle", 64'(stkUnderflow), 64'(0));
    stackOp(1'b1, 1'b1, 1'b0, 16'h0055, 16'h0066);
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    check("R13 stack usable after underflow", 64'({restoreX, statXOut, statYOut}), 64'({1'b1, 16'h0055, 16'h0066}));
  endtask

  // R11
  task automatic testStackScalar();
    stackOp(1'b1, 1'b1, 1'b0, 16'h0077, 16'h0088);
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    stackOp(1'b0, 1'b1, 1'b0, 16'h0099, 16'h00AA);
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    check("R11 non-SIMD push keeps Y word", 64'({restoreY, statXOut, statYOut}), 64'({1'b1, 16'h0099, 16'h0088}));
    stackOp(1'b1, 1'b1, 1'b0, 16'h0101, 16'h0202);
    stackOp(1'b0, 1'b0, 1'b1, '0, '0);
    check("R11 non-SIMD pop X only", 64'({restoreX, restoreY, statXOut, statYOut}), 64'({2'b10, 16'h0101, 16'h0088}));
  endtask

  // R12 R14
  task automatic testOverflow();
    for (int i = 1; i <= DEPTH; i++) begin
      stackOp(1'b1, 1'b1, 1'b0, 16'(i), 16'(16'h100 + i));
      check("R12 no overflow while filling", 64'(stkOverflow), 64'(0));
    end
    stackOp(1'b1, 1'b1, 1'b0, 16'hDEAD, 16'hBEEF);
    check("R12 overflow flag", 64'(stkOverflow), 64'(1));
    @(negedge clk);
    check("R12 overflow one cycle", 64'(stkOverflow), 64'(0));
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    check("R12 top unchanged", 64'({statXOut, statYOut}), 64'({16'd5, 16'h0105}));
    stackOp(1'b1, 1'b1, 1'b1, 16'hCAFE, 16'hF00D);
    check("R14 collision quiet", 64'({restoreX, restoreY, stkOverflow, stkUnderflow}), 64'(0));
    stackOp(1'b1, 1'b0, 1'b1, '0, '0);
    check("R14 contents unchanged", 64'({statXOut, statYOut}), 64'({16'd4, 16'h0104}));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("reset state", 64'({restoreX, restoreY, stkOverflow, stkUnderflow, statXOut, statYOut}), 64'(0));
    testMoves();
    testBranchAddr();
    testModes();
    testStackSimd();
    testUnderflow();
    testStackScalar();
    testOverflow();
    summary();
    $finish;
  end

endmodule